// File: doc/BRIEF.md
# Vector Register File with Upper-Half Control

This block holds sixteen 256-bit vector registers. It has two combinational read ports and one write port. Each write is tagged with a width, either narrow (the low 128 bits, which form the legacy-width view) or wide (the whole register). Each write is also tagged with an encoding class, either legacy or zero-extending. For a narrow write, the encoding class decides what happens to the upper half of the target register. A legacy write merges into the old upper bits and keeps them. A zero-extending write clears everything above the narrow width.

A separate one-cycle command clears the upper half of every register at once and leaves every low half as it was. A status output tells surrounding logic whether any upper half may hold nonzero data. Wide writes set this status, and only the bulk clear (or reset) drops it. Reads always see the register's value at the end of the current cycle, so a same-cycle write or clear is already visible on the read data.

Top module: `vec_regfile`

## Requirements
- R1: After reset deasserts, every register reads as all zeros and `dirty_o` is 0.
- R2: A narrow write (`wwide_i`=0) of the legacy class (`wzext_i`=0) replaces bits 127:0 of the target and leaves bits 255:128 unchanged.
- R3: A narrow write of the zero-extending class (`wzext_i`=1) replaces bits 127:0 of the target and sets bits 255:128 to zero.
- R4: A wide write (`wwide_i`=1) replaces all 256 bits of the target, whatever the value of `wzext_i`.
- R5: When `clr_upper_i` is 1 for one cycle, bits 255:128 of every register become zero and every low half is kept.
- R6: On a narrow write, bits 255:128 of `wdata_i` have no effect on any register.
- R7: A wide write in a cycle without `clr_upper_i` makes `dirty_o` read 1 from the next cycle on.
- R8: `dirty_o` falls to 0 in the cycle after `clr_upper_i`. Without a clear and without a wide write it holds its value, and narrow writes of either class leave it unchanged.
- R9: A read port whose address equals `waddr_i` while `we_i` is 1 returns the value after that write in the same cycle.
- R10: When a write and `clr_upper_i` fall in the same cycle, the write is applied first and the clear second. The written register ends with its new low half and a zero upper half, and `dirty_o` ends at 0 even for a wide write.
- R11: The two read ports address registers independently, and each returns its own register in the same cycle.
- R12: While `we_i` and `clr_upper_i` are both 0, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable |
| waddr_i | input | 4 | Write register index |
| wwide_i | input | 1 | 1: full-width write, 0: narrow write |
| wzext_i | input | 1 | 1: zero-extending class, 0: legacy class |
| wdata_i | input | 256 | Write data; only bits 127:0 are used on narrow writes |
| clr_upper_i | input | 1 | Clear the upper half of all registers this cycle |
| raddr_i | input | 2x4 | Read register index, one per port |
| rdata_o | output | 2x256 | Read data, one per port, end-of-cycle value |
| dirty_o | output | 1 | Some upper half may be nonzero |

## Verification
The bench builds the block with its default parameters: sixteen registers, 256-bit full width, 128-bit narrow width and two read ports. With these values it can write the first and last register indices and put random data on both halves, so lost or leaked upper bits show up. Sixteen registers also make the bulk clear visible on every entry, and the model reads all of them back after each clear. Because both read ports are present, the bench can read the written register and an unrelated one in the same cycle. A mix of random operations then covers coincident write-and-clear cycles and same-cycle forwarding.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

  typedef struct packed {
    logic wide;  // full-width write
    logic zext;  // zero-extending encoding class
  } wr_mode_t;

endpackage

// File: rtl/vrf_wr_merge.sv
module vrf_wr_merge
  import vrf_pkg::*;
#(
  parameter int FULL_W   = 256,
  parameter int LEGACY_W = 128
) (
  input  logic [FULL_W-1:0] old_i,
  input  logic [FULL_W-1:0] wdata_i,
  input  wr_mode_t          mode_i,
  output logic [FULL_W-1:0] new_o
);

  localparam int UPPER_W = FULL_W - LEGACY_W;

  logic [UPPER_W-1:0] upper_keep;

  always_comb begin
    upper_keep = mode_i.zext ? '0 : old_i[FULL_W-1:LEGACY_W];
    if (mode_i.wide) new_o = wdata_i;
    else             new_o = {upper_keep, wdata_i[LEGACY_W-1:0]};
  end

endmodule

// File: rtl/vrf_bank.sv
module vrf_bank
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int FULL_W   = 256,
  parameter int LEGACY_W = 128,
  parameter int AW       = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [AW-1:0]                    waddr_i,
  input  wr_mode_t                         mode_i,
  input  logic [FULL_W-1:0]                wdata_i,
  input  logic                             clr_upper_i,
  output logic [NUM_REGS-1:0][FULL_W-1:0]  nxt_o
);

  localparam int UPPER_W = FULL_W - LEGACY_W;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [FULL_W-1:0] q;
    logic [FULL_W-1:0] merged;
    logic [FULL_W-1:0] after_wr;
    logic              hit;

    assign hit = we_i && (waddr_i == AW'(i));

    vrf_wr_merge #(
      .FULL_W  (FULL_W),
      .LEGACY_W(LEGACY_W)
    ) u_merge (
      .old_i  (q),
      .wdata_i(wdata_i),
      .mode_i (mode_i),
      .new_o  (merged)
    );

    // write first, then bulk clear
    always_comb begin
      after_wr = hit ? merged : q;
      nxt_o[i] = clr_upper_i ? {UPPER_W'(0), after_wr[LEGACY_W-1:0]} : after_wr;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= nxt_o[i];
    end
  end

endmodule

// File: rtl/vrf_rd_port.sv
module vrf_rd_port #(
  parameter int NUM_REGS = 16,
  parameter int FULL_W   = 256,
  parameter int AW       = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][FULL_W-1:0] regs_i,
  input  logic [AW-1:0]                   addr_i,
  output logic [FULL_W-1:0]               data_o
);

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == AW'(i)) data_o = regs_i[i];
    end
  end

endmodule

// File: rtl/vrf_dirty.sv
module vrf_dirty (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wide_wr_i,
  input  logic clr_upper_i,
  output logic dirty_o
);

  logic dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          dirty_q <= 1'b0;
    else if (clr_upper_i) dirty_q <= 1'b0;  // clear wins over same-cycle write
    else if (wide_wr_i)   dirty_q <= 1'b1;
  end

  assign dirty_o = dirty_q;

endmodule

// File: rtl/vec_regfile.sv
module vec_regfile
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int FULL_W   = 256,
  parameter int LEGACY_W = 128,
  parameter int N_RD     = 2,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [AW-1:0]                waddr_i,
  input  logic                         wwide_i,
  input  logic                         wzext_i,
  input  logic [FULL_W-1:0]            wdata_i,
  input  logic                         clr_upper_i,
  input  logic [N_RD-1:0][AW-1:0]      raddr_i,
  output logic [N_RD-1:0][FULL_W-1:0]  rdata_o,
  output logic                         dirty_o
);

  wr_mode_t                        mode;
  logic [NUM_REGS-1:0][FULL_W-1:0] nxt;

  assign mode = '{wide: wwide_i, zext: wzext_i};

  vrf_bank #(
    .NUM_REGS(NUM_REGS),
    .FULL_W  (FULL_W),
    .LEGACY_W(LEGACY_W),
    .AW      (AW)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .waddr_i    (waddr_i),
    .mode_i     (mode),
    .wdata_i    (wdata_i),
    .clr_upper_i(clr_upper_i),
    .nxt_o      (nxt)
  );

  // reads see end-of-cycle state
  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    vrf_rd_port #(
      .NUM_REGS(NUM_REGS),
      .FULL_W  (FULL_W),
      .AW      (AW)
    ) u_rd (
      .regs_i(nxt),
      .addr_i(raddr_i[p]),
      .data_o(rdata_o[p])
    );
  end

  vrf_dirty u_dirty (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wide_wr_i  (we_i && wwide_i),
    .clr_upper_i(clr_upper_i),
    .dirty_o    (dirty_o)
  );

endmodule

// File: rtl/vrf_chk.sv
module vrf_chk #(
  parameter int NUM_REGS = 16,
  parameter int FULL_W   = 256,
  parameter int LEGACY_W = 128,
  parameter int N_RD     = 2,
  parameter int AW       = $clog2(NUM_REGS)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         we_i,
  input logic [AW-1:0]                waddr_i,
  input logic                         wwide_i,
  input logic                         wzext_i,
  input logic [FULL_W-1:0]            wdata_i,
  input logic                         clr_upper_i,
  input logic [N_RD-1:0][AW-1:0]      raddr_i,
  input logic [N_RD-1:0][FULL_W-1:0]  rdata_o,
  input logic                         dirty_o
);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_dirty_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wwide_i && !clr_upper_i) |=> dirty_o);

  p_dirty_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_upper_i |=> !dirty_o);

  p_dirty_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_upper_i && !(we_i && wwide_i)) |=> $stable(dirty_o));

  for (genvar p = 0; p < N_RD; p++) begin : g_p
    p_clr_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_upper_i |-> (rdata_o[p][FULL_W-1:LEGACY_W] == '0));

    p_wide_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wwide_i && !clr_upper_i && raddr_i[p] == waddr_i)
      |-> (rdata_o[p] == wdata_i));

    p_fwd_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && raddr_i[p] == waddr_i)
      |-> (rdata_o[p][LEGACY_W-1:0] == wdata_i[LEGACY_W-1:0]));

    p_zext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !wwide_i && wzext_i && raddr_i[p] == waddr_i)
      |-> (rdata_o[p][FULL_W-1:LEGACY_W] == '0));

    p_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && we_i && !wwide_i && !wzext_i && !clr_upper_i &&
       raddr_i[p] == waddr_i && raddr_i[p] == $past(raddr_i[p]))
      |-> (rdata_o[p][FULL_W-1:LEGACY_W] == $past(rdata_o[p][FULL_W-1:LEGACY_W])));

    p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && !we_i && !clr_upper_i && raddr_i[p] == $past(raddr_i[p]))
      |-> (rdata_o[p] == $past(rdata_o[p])));
  end

endmodule

bind vec_regfile vrf_chk #(
  .NUM_REGS(NUM_REGS),
  .FULL_W  (FULL_W),
  .LEGACY_W(LEGACY_W),
  .N_RD    (N_RD),
  .AW      (AW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .waddr_i    (waddr_i),
  .wwide_i    (wwide_i),
  .wzext_i    (wzext_i),
  .wdata_i    (wdata_i),
  .clr_upper_i(clr_upper_i),
  .raddr_i    (raddr_i),
  .rdata_o    (rdata_o),
  .dirty_o    (dirty_o)
);

// File: tb/vec_regfile_tb.sv
`timescale 1ns/1ps
module vec_regfile_tb;

  localparam int NR = 16;
  localparam int FW = 256;
  localparam int LW = 128;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic wwide = 1'b0;
  logic wzext = 1'b0;
  logic [FW-1:0] wdata = '0;
  logic clr = 1'b0;
  logic [1:0][AW-1:0] raddr = '0;
  logic [1:0][FW-1:0] rdata;
  logic dirty;

  always #2.5 clk = ~clk;

  vec_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .waddr_i(waddr),
    .wwide_i(wwide), .wzext_i(wzext), .wdata_i(wdata),
    .clr_upper_i(clr), .raddr_i(raddr), .rdata_o(rdata), .dirty_o(dirty)
  );

  logic [FW-1:0] mdl [NR];
  logic          mdl_dirty;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 0;

  function automatic logic [FW-1:0] rnd_vec();
    logic [FW-1:0] v;
    for (int k = 0; k < FW/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [FW-1:0] mdl_next(int idx);
    logic [FW-1:0] v = mdl[idx];
    if (we && int'(waddr) == idx) begin
      if (wwide) v = wdata;
      else begin
        v[LW-1:0] = wdata[LW-1:0];
        if (wzext) v[FW-1:LW] = '0;
      end
    end
    if (clr) v[FW-1:LW] = '0;
    return v;
  endfunction

  task automatic check_vec(string tag, int port, logic [FW-1:0] act, logic [FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s port%0d: actual %h expected %h", tag, port, act, exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s dirty: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare combinational reads, commit model
  task automatic step(input string tag, input logic w, input int wa, input logic wd,
                      input logic zx, input logic [FW-1:0] d, input logic c,
                      input int r0, input int r1);
    @(negedge clk);
    we = w; waddr = AW'(wa); wwide = wd; wzext = zx; wdata = d; clr = c;
    raddr[0] = AW'(r0); raddr[1] = AW'(r1);
    #1;
    check_vec(tag, 0, rdata[0], mdl_next(r0));
    check_vec(tag, 1, rdata[1], mdl_next(r1));
    check_bit(tag, dirty, mdl_dirty);
    begin
      logic [FW-1:0] nx [NR];
      for (int i = 0; i < NR; i++) nx[i] = mdl_next(i);
      for (int i = 0; i < NR; i++) mdl[i] = nx[i];
    end
    if (c) mdl_dirty = 1'b0;
    else if (w && wd) mdl_dirty = 1'b1;
  endtask

  task automatic idle_read_all(string tag);
    for (int i = 0; i < NR; i += 2) step(tag, 0, 0, 0, 0, rnd_vec(), 0, i, i + 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    mdl_dirty = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    idle_read_all("R1");

    // R4 / R7 / R9: wide writes of both classes, forwarded read on port 0
    for (int i = 0; i < NR; i++)
      step("R4", 1, i, 1, i[0], rnd_vec(), 0, i, (i + 5) % NR);
    step("R7", 0, 0, 0, 0, '0, 0, 0, NR - 1);

    // R2 / R6: legacy narrow writes, junk in upper data bits
    for (int i = 0; i < NR; i += 3)
      step("R2", 1, i, 0, 0, rnd_vec(), 0, i, (i + 1) % NR);
    step("R6", 1, NR - 1, 0, 0, {{(FW-LW){1'b1}}, LW'(0)}, 0, NR - 1, 0);
    idle_read_all("R6");

    // R3: zero-extending narrow writes; R8: dirty untouched by narrow writes
    for (int i = 1; i < NR; i += 4)
      step("R3", 1, i, 0, 1, rnd_vec(), 0, i, (i + 2) % NR);
    step("R8", 0, 0, 0, 0, '0, 0, 1, 2);

    // R12: no enable, busy write inputs
    for (int i = 0; i < 4; i++)
      step("R12", 0, i, i[0], i[1], rnd_vec(), 0, i, i + 8);
    idle_read_all("R12");

    // R5 / R8: bulk clear
    step("R5", 0, 0, 0, 0, '0, 1, 0, NR - 1);
    idle_read_all("R5");
    step("R8", 0, 0, 0, 0, '0, 0, 3, 4);

    // R10: wide write coinciding with clear
    for (int i = 0; i < NR; i++) step("R4", 1, i, 1, 0, rnd_vec(), 0, i, 0);
    step("R10", 1, 7, 1, 0, rnd_vec(), 1, 7, 6);
    step("R10", 0, 0, 0, 0, '0, 0, 7, 8);
    idle_read_all("R10");

    // R11: independent ports, random mix with same-cycle forwarding
    for (int n = 0; n < 400; n++) begin
      int wa = $urandom_range(NR - 1);
      int r0 = ($urandom_range(3) == 0) ? wa : $urandom_range(NR - 1);
      step("R11", $urandom_range(1) == 1, wa, $urandom_range(1) == 1,
           $urandom_range(1) == 1, rnd_vec(), $urandom_range(15) == 0,
           r0, $urandom_range(NR - 1));
    end
    step("R9", 1, 2, 0, 0, rnd_vec(), 0, 2, 2);
    idle_read_all("R11");

    finish_run();
  end

endmodule